// File: doc/BRIEF.md
# Sixteen-Bit Word ALU with Status Register

This block does the word arithmetic and logic for a small CPU that keeps its general registers in memory. Each cycle it takes a source word, a destination word and a three-bit operation code. It gives back three things. The first is the result. The second is a write-enable that tells the sequencer whether the result goes back to the destination. The third is the candidate values of five status bits. The supported operations are move, add, subtract, compare, set-ones (OR) and set-zeros (destination with the source bits cleared). The result, the write-enable and the candidate flags are combinational. The status register takes the candidate flags on a clock edge only when the sequencer pulses the flag-update strobe.

Status bit i of the `status` and `flags_next` ports holds flag STi:
- ST0 is logical greater.
- ST1 is arithmetic greater.
- ST2 is equal.
- ST3 is carry.
- ST4 is overflow.

Compare computes the same difference as subtract, but it only feeds the flags.

Top module: `alu16_core`

## Requirements
- R1: The operation codes are 0 move, 1 add, 2 subtract, 3 compare, 4 set-ones, 5 set-zeros. Move gives `result` = `src` with `wr_en` = 1.
- R2: Add gives `result` = (`src` + `dst`) mod 65536 and `wr_en` = 1. ST3 (bit 3) is the carry out of bit 15.
- R3: For add, ST4 (bit 4) is 1 exactly when both operands share a sign and the result sign differs from it.
- R4: Subtract gives `result` = (`dst` − `src`) mod 65536 and `wr_en` = 1. ST3 is 1 when there is no borrow (`dst` ≥ `src` unsigned). ST4 is 1 when the operand signs differ and the result sign differs from the sign of `dst`.
- R5: Set-ones gives `src` | `dst`. Set-zeros gives `dst` & ~`src`. Both drive `wr_en` = 1.
- R6: Compare drives `wr_en` = 0. It sets ST0 (bit 0) = `src` > `dst` unsigned, ST1 (bit 1) = `src` > `dst` signed, and ST2 (bit 2) = `src` == `dst`. It sets ST3 and ST4 as subtract would.
- R7: For move, add, subtract, set-ones and set-zeros, ST0 = result nonzero, ST1 = result signed greater than zero, and ST2 = result zero.
- R8: Move, set-ones and set-zeros pass ST3 and ST4 through from the current `status` unchanged.
- R9: `status` loads `flags_next` on a rising clock edge only when `flag_upd` is 1. Otherwise it holds.
- R10: A synchronous active-high `rst` clears `status` to 0.
- R11: Codes 6 and 7 are idle. They drive `result` = `dst` and `wr_en` = 0, and `flags_next` equals `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| flag_upd | input | 1 | Load strobe for the status register |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Result should be written back |
| flags_next | output | 5 | Candidate status bits, bit i = STi |
| status | output | 5 | Registered status bits, bit i = STi |

## Verification
The checker watches several properties on every cycle:
- Compare and the idle codes never request a write.
- Move and the logical operations carry ST3/ST4 through from `status`.
- ST2 tracks a zero result, and an equal condition never coexists with either greater flag.
- The add sum matches its operands.
- `status` either holds or loads exactly what `flags_next` showed.

Only the directed scenarios can show the specific carry, borrow and overflow edges. These are 0xFFFF+1, 0x7FFF+1 and 0x8000−1, and compare ordering where the signed and unsigned answers disagree. The scenarios also show that a carry captured by an add survives a following logical operation, and that a mid-run reset clears the register.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int NFLAG = 5;
  localparam int F_LGT = 0;
  localparam int F_AGT = 1;
  localparam int F_EQ  = 2;
  localparam int F_CY  = 3;
  localparam int F_OV  = 4;

  typedef enum logic [2:0] {
    OP_MOVE = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_CMP  = 3'd3,
    OP_SETO = 3'd4,
    OP_SETZ = 3'd5,
    OP_IDL6 = 3'd6,
    OP_IDL7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    KIND_ARITH,
    KIND_LOGIC,
    KIND_CMP,
    KIND_IDLE
  } kind_e;

  function automatic kind_e op_kind(input op_e op);
    case (op)
      OP_ADD, OP_SUB:           op_kind = KIND_ARITH;
      OP_MOVE, OP_SETO, OP_SETZ: op_kind = KIND_LOGIC;
      OP_CMP:                   op_kind = KIND_CMP;
      default:                  op_kind = KIND_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_src,
  input  logic [W-1:0] b_dst,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] eff;
  logic [W:0]   full;

  always_comb begin
    eff  = do_sub ? ~a_src : a_src;
    full = {1'b0, b_dst} + {1'b0, eff} + {{W{1'b0}}, do_sub};
    sum  = full[W-1:0];
    cout = full[W];
    // signed overflow: addends share a sign that the sum does not
    ovf  = (b_dst[MSB] == eff[MSB]) && (full[MSB] != b_dst[MSB]);
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
  parameter int W = 16
) (
  input  alu16_pkg::op_e op,
  input  logic [W-1:0]   a_src,
  input  logic [W-1:0]   b_dst,
  output logic [W-1:0]   res
);
  import alu16_pkg::*;

  always_comb begin
    case (op)
      OP_MOVE: res = a_src;
      OP_SETO: res = a_src | b_dst;
      OP_SETZ: res = b_dst & ~a_src;
      default: res = b_dst;
    endcase
  end
endmodule

// File: rtl/alu16_flagcalc.sv
module alu16_flagcalc #(
  parameter int W = 16
) (
  input  alu16_pkg::op_e                op,
  input  logic [W-1:0]                  a_src,
  input  logic [W-1:0]                  b_dst,
  input  logic [W-1:0]                  res,
  input  logic                          cout,
  input  logic                          ovf,
  input  logic [alu16_pkg::NFLAG-1:0]   cur,
  output logic [alu16_pkg::NFLAG-1:0]   nxt,
  output logic                          wr
);
  import alu16_pkg::*;

  localparam int MSB = W - 1;

  logic res_zero;
  logic res_pos;

  always_comb begin
    res_zero = (res == '0);
    res_pos  = !res[MSB] && !res_zero;
    nxt      = cur;
    wr       = 1'b0;
    case (op_kind(op))
      KIND_ARITH: begin
        nxt[F_LGT] = !res_zero;
        nxt[F_AGT] = res_pos;
        nxt[F_EQ]  = res_zero;
        nxt[F_CY]  = cout;
        nxt[F_OV]  = ovf;
        wr         = 1'b1;
      end
      KIND_LOGIC: begin
        nxt[F_LGT] = !res_zero;
        nxt[F_AGT] = res_pos;
        nxt[F_EQ]  = res_zero;
        wr         = 1'b1;
      end
      KIND_CMP: begin
        nxt[F_LGT] = a_src > b_dst;
        nxt[F_AGT] = $signed(a_src) > $signed(b_dst);
        nxt[F_EQ]  = a_src == b_dst;
        nxt[F_CY]  = cout;
        nxt[F_OV]  = ovf;
      end
      default: begin
        nxt = cur;
      end
    endcase
  end
endmodule

// File: rtl/alu16_status.sv
module alu16_status #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NF-1:0] d,
  output logic [NF-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)       q[i] <= 1'b0;
        else if (load) q[i] <= d[i];
      end
    end
  endgenerate
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2:0]                  op_sel,
  input  logic [W-1:0]                src,
  input  logic [W-1:0]                dst,
  input  logic                        flag_upd,
  output logic [W-1:0]                result,
  output logic                        wr_en,
  output logic [alu16_pkg::NFLAG-1:0] flags_next,
  output logic [alu16_pkg::NFLAG-1:0] status
);
  import alu16_pkg::*;

  op_e          op;
  logic         is_sub;
  logic [W-1:0] as_sum;
  logic         as_cout;
  logic         as_ovf;
  logic [W-1:0] lg_res;

  always_comb begin
    op     = op_e'(op_sel);
    is_sub = (op == OP_SUB) || (op == OP_CMP);
  end

  alu16_addsub #(.W(W)) u_addsub (
    .a_src (src),
    .b_dst (dst),
    .do_sub(is_sub),
    .sum   (as_sum),
    .cout  (as_cout),
    .ovf   (as_ovf)
  );

  alu16_logic #(.W(W)) u_logic (
    .op   (op),
    .a_src(src),
    .b_dst(dst),
    .res  (lg_res)
  );

  always_comb begin
    case (op_kind(op))
      KIND_ARITH, KIND_CMP: result = as_sum;
      default:              result = lg_res;
    endcase
  end

  alu16_flagcalc #(.W(W)) u_flags (
    .op   (op),
    .a_src(src),
    .b_dst(dst),
    .res  (result),
    .cout (as_cout),
    .ovf  (as_ovf),
    .cur  (status),
    .nxt  (flags_next),
    .wr   (wr_en)
  );

  alu16_status #(.NF(NFLAG)) u_status (
    .clk (clk),
    .rst (rst),
    .load(flag_upd),
    .d   (flags_next),
    .q   (status)
  );
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op_sel,
  input logic [W-1:0] src,
  input logic [W-1:0] dst,
  input logic         flag_upd,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [4:0]   flags_next,
  input logic [4:0]   status
);
  logic is_logic;
  logic writes_flags;
  assign is_logic     = (op_sel == 3'd0) || (op_sel == 3'd4) || (op_sel == 3'd5);
  assign writes_flags = is_logic || (op_sel == 3'd1) || (op_sel == 3'd2);

  // R6, R11: no write request for compare or idle codes
  p_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd3 || op_sel[2:1] == 2'b11) |-> !wr_en);

  // R8: logical ops carry C and OV through
  p_keep_cv_r8: assert property (@(posedge clk) disable iff (rst)
    is_logic |-> flags_next[4:3] == status[4:3]);

  // R7: equal flag tracks a zero result
  p_eq_zero_r7: assert property (@(posedge clk) disable iff (rst)
    writes_flags |-> flags_next[2] == (result == '0));

  // R6, R7: equal excludes both greater flags
  p_eq_excl_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel[2:1] != 2'b11 && flags_next[2]) |-> (flags_next[1:0] == 2'b00));

  // R2: add result is the modular sum
  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd1) |-> result == W'(src + dst));

  // R9: status holds without strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !flag_upd |=> status == $past(status));

  // R9: status loads candidate flags with strobe
  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    flag_upd |=> status == $past(flags_next));

  // R11: idle codes leave flags as they are
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (op_sel[2:1] == 2'b11) |-> flags_next == status);
endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .src(src), .dst(dst),
  .flag_upd(flag_upd), .result(result), .wr_en(wr_en),
  .flags_next(flags_next), .status(status)
);

// File: tb/alu16_core_test.sv
module alu16_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = 3'd0;
  logic [15:0] src = '0;
  logic [15:0] dst = '0;
  logic        flag_upd = 1'b0;
  logic [15:0] result;
  logic        wr_en;
  logic [4:0]  flags_next;
  logic [4:0]  status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu16_core uut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .src(src), .dst(dst),
    .flag_upd(flag_upd), .result(result), .wr_en(wr_en),
    .flags_next(flags_next), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply a combinational vector and check all three outputs
  task automatic vec(input string tag, input logic [2:0] op, input logic [15:0] s,
                     input logic [15:0] d, input logic [15:0] er, input logic ew,
                     input logic [4:0] ef);
    @(negedge clk);
    op_sel = op; src = s; dst = d; flag_upd = 1'b0;
    #1;
    chk({tag, " result"}, 32'(result), 32'(er));
    chk({tag, " wr_en"}, 32'(wr_en), 32'(ew));
    chk({tag, " flags"}, 32'(flags_next), 32'(ef));
  endtask

  task automatic capture(input logic [2:0] op, input logic [15:0] s, input logic [15:0] d);
    @(negedge clk);
    op_sel = op; src = s; dst = d; flag_upd = 1'b1;
    @(negedge clk);
    flag_upd = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 reset status", 32'(status), 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_move;
    vec("R1 move", 3'd0, 16'hA5A5, 16'h0000, 16'hA5A5, 1'b1, 5'b00001);
  endtask

  task automatic t_add;
    vec("R2 add 1234+1", 3'd1, 16'h0001, 16'h1234, 16'h1235, 1'b1, 5'b00011);
    vec("R2 add 1+1",    3'd1, 16'h0001, 16'h0001, 16'h0002, 1'b1, 5'b00011);
    vec("R2 add carry",  3'd1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 5'b01100);
    vec("R3 add ovf",    3'd1, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 5'b10001);
  endtask

  task automatic t_sub;
    vec("R4 sub 5-3",    3'd2, 16'h0003, 16'h0005, 16'h0002, 1'b1, 5'b01011);
    vec("R4 sub borrow", 3'd2, 16'h0005, 16'h0003, 16'hFFFE, 1'b1, 5'b00001);
    vec("R4 sub ovf",    3'd2, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 5'b11011);
  endtask

  task automatic t_cmp;
    vec("R6 cmp gt",     3'd3, 16'h0005, 16'h0003, 16'hFFFE, 1'b0, 5'b00011);
    vec("R6 cmp lgt",    3'd3, 16'hFFFF, 16'h0001, 16'h0002, 1'b0, 5'b00001);
    vec("R6 cmp eq",     3'd3, 16'h0007, 16'h0007, 16'h0000, 1'b0, 5'b01100);
  endtask

  task automatic t_logic;
    vec("R5 seto",       3'd4, 16'h0F00, 16'hF0F0, 16'hFFF0, 1'b1, 5'b00001);
    vec("R5 setz",       3'd5, 16'h00FF, 16'hFFFF, 16'hFF00, 1'b1, 5'b00001);
    vec("R7 setz zero",  3'd5, 16'h00FF, 16'h00FF, 16'h0000, 1'b1, 5'b00100);
    vec("R7 setz pos",   3'd5, 16'h0003, 16'h0F0F, 16'h0F0C, 1'b1, 5'b00011);
  endtask

  task automatic t_carry_kept;
    capture(3'd1, 16'hFFFF, 16'h0001);
    chk("R9 captured add", 32'(status), 32'(5'b01100));
    vec("R8 seto keeps C zero", 3'd4, 16'h0000, 16'h0000, 16'h0000, 1'b1, 5'b01100);
    vec("R8 seto keeps C",      3'd4, 16'h0001, 16'h0000, 16'h0001, 1'b1, 5'b01011);
    capture(3'd4, 16'h0001, 16'h0000);
    chk("R8 status after seto", 32'(status), 32'(5'b01011));
    capture(3'd1, 16'h7FFF, 16'h0001);
    chk("R9 captured ovf", 32'(status), 32'(5'b10001));
    vec("R8 move keeps OV", 3'd0, 16'h0000, 16'h1111, 16'h0000, 1'b1, 5'b10100);
  endtask

  task automatic t_hold;
    vec("R9 hold a", 3'd2, 16'h0001, 16'h0000, 16'hFFFF, 1'b1, 5'b00001);
    @(negedge clk);
    op_sel = 3'd1; src = 16'hFFFF; dst = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R9 hold status", 32'(status), 32'(5'b10001));
  endtask

  task automatic t_idle;
    vec("R11 idle6", 3'd6, 16'h1234, 16'h5678, 16'h5678, 1'b0, 5'b10001);
    vec("R11 idle7", 3'd7, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 5'b10001);
    capture(3'd6, 16'h1234, 16'h5678);
    chk("R11 idle capture", 32'(status), 32'(5'b10001));
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset", 32'(status), 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_move();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_carry_kept();
    t_hold();
    t_idle();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule